// File: doc/BRIEF.md
# Dual-Channel Console Interrupt Register Block

This block is the host-visible register front end for a pair of serial character channels: channel A (console) and channel B (auxiliary). A host reaches it over a simple single-cycle read/write bus. Each channel has a status register, a command register and a holding register. One shared address holds two registers: a write loads the interrupt mask and a read returns the interrupt status. A single registered interrupt line goes to the host.

Received bytes come in on per-channel valid/ready byte ports. Transmitted bytes leave as one-cycle valid strobes with the byte. A periodic tick input stands in for a real transmitter: on every second tick, transmit-ready interrupts are raised. Baud generation, framing, mode and auxiliary control registers and the counter/timer are not part of the block. Accesses to those addresses read as zero and have no effect.

A status bit is only set while its mask bit is already set. Reading channel A status drops the interrupt line. Reading channel B status leaves the line as it is.

Top module: `con_irq_regs`

## Requirements
- R1: After reset the interrupt line is low, the interrupt status reads 0x00, the mask is 0x00 and the tick counter is zero, so the first transmit-ready event needs two fresh ticks.
- R2: A channel status read returns bit 2 (0x04) always set, bit 0 (0x01) equal to that channel's receive-valid input, and all other bits zero.
- R3: When a new byte appears on a channel's receive port and that channel's receive mask bit is set (A: 0x02, B: 0x20), the matching status bit is set and the interrupt line goes high on the next clock edge. With the mask bit clear, neither the status nor the line changes.
- R4: Every second tick sets status bits 0x01 and 0x10 and raises the interrupt line, provided mask bit 0x01 or 0x10 is set. Otherwise the event has no effect.
- R5: A read of channel A status drives the interrupt line low on the next edge, unless an interrupt is being set in that same cycle. A read of channel B status leaves the line unchanged.
- R6: A holding-register write produces a one-cycle transmit strobe on that channel with the written byte, starting on the next cycle. It also clears that channel's transmit-ready status bit (A: 0x01, B: 0x10).
- R7: A holding-register read with a byte available returns the byte and pops it (ready asserted in that cycle). With no byte available it returns 0x00 and does not pop. Either way it clears the channel's receive-ready status bit (A: 0x02, B: 0x20).
- R8: A command-register write with bit 3 (0x08) set produces a one-cycle flush request for that channel on the next cycle. With bit 3 clear, no flush request is made.
- R9: The register offsets are: status A 0x40C, command A 0x414, holding A 0x41C, interrupt status/mask 0x42C. Channel B sits 0x40 above channel A. A write to 0x42C changes only the mask, never the status that a read there returns.
- R10: Every other offset, including the mode and auxiliary-control addresses, reads 0x00 and ignores writes. Command-register reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_valid | input | 2 | Receive byte available, bit 0 = channel A |
| rx_data | input | 16 | Receive bytes, [7:0] = A, [15:8] = B |
| rx_ready | output | 2 | Pop of the receive byte |
| tx_valid | output | 2 | Transmit strobe per channel |
| tx_data | output | 16 | Transmit bytes, [7:0] = A, [15:8] = B |
| flush_req | output | 2 | Output flush request per channel |
| tick | input | 1 | Periodic tick, one cycle per pulse |
| irq | output | 1 | Interrupt to host |

## Verification
A wrong internal state shows up at the interrupt pin and on the read bus within one clock. A stale mask or status bit gives a wrong value on the next 0x42C read. It also makes the line rise when it should not, in the cycle right after the arrival or tick that should have been gated. A tick counter that is off by one moves the transmit-ready event by a whole tick, so the bench reads the status after each single tick. A broken arrival tracker either repeats an interrupt after the status is cleared or misses the second byte.

// File: rtl/con_irq_pkg.sv
package con_irq_pkg;

    localparam int CH_N      = 2;
    localparam int BYTE_W    = 8;
    localparam int CH_ISR_SH = 4;   // interrupt bit stride between channels

    // status register bit positions
    localparam int STS_RX_BIT  = 0;
    localparam int STS_TX_BIT  = 2;
    // command register flush bit
    localparam int CMD_FLUSH_BIT = 3;

    function automatic int tx_isr_bit(input int ch);
        return ch * CH_ISR_SH;
    endfunction

    function automatic int rx_isr_bit(input int ch);
        return ch * CH_ISR_SH + 1;
    endfunction

    function automatic logic [BYTE_W-1:0] tx_isr_all();
        logic [BYTE_W-1:0] m;
        m = '0;
        for (int c = 0; c < CH_N; c++) m[tx_isr_bit(c)] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic [BYTE_W-1:0]        isr;
        logic [BYTE_W-1:0]        imr;
        logic                     irq;
        logic [CH_N-1:0]          tx_vld;
        logic [CH_N*BYTE_W-1:0]   tx_dat;
        logic [CH_N-1:0]          flush;
    } core_t;

endpackage

// File: rtl/con_tick_div.sv
module con_tick_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic fire
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        fire  = tick && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (tick) cnt_d = fire ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/con_rx_track.sv
module con_rx_track (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic pop,
    output logic arrive
);
    logic seen_d, seen_q;

    always_comb begin
        arrive = rx_valid && !seen_q;
        seen_d = rx_valid && !pop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end
endmodule

// File: rtl/con_addr_dec.sv
module con_addr_dec #(
    parameter int ADDR_W     = 12,
    parameter int CH_N       = 2,
    parameter int STS_A_OFS  = 'h40C,
    parameter int CMD_A_OFS  = 'h414,
    parameter int HOLD_A_OFS = 'h41C,
    parameter int ISR_OFS    = 'h42C,
    parameter int CH_STRIDE  = 'h40
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_N-1:0]   hit_sts,
    output logic [CH_N-1:0]   hit_cmd,
    output logic [CH_N-1:0]   hit_hold,
    output logic              hit_isr
);
    localparam logic [ADDR_W-1:0] ISR_A = ADDR_W'(ISR_OFS);

    assign hit_isr = (addr == ISR_A);

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] S_A = ADDR_W'(STS_A_OFS  + ch * CH_STRIDE);
        localparam logic [ADDR_W-1:0] C_A = ADDR_W'(CMD_A_OFS  + ch * CH_STRIDE);
        localparam logic [ADDR_W-1:0] H_A = ADDR_W'(HOLD_A_OFS + ch * CH_STRIDE);
        assign hit_sts[ch]  = (addr == S_A);
        assign hit_cmd[ch]  = (addr == C_A);
        assign hit_hold[ch] = (addr == H_A);
    end
endmodule

// File: rtl/con_irq_regs.sv
module con_irq_regs
    import con_irq_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int TICK_DIV   = 2,
    parameter int STS_A_OFS  = 'h40C,
    parameter int CMD_A_OFS  = 'h414,
    parameter int HOLD_A_OFS = 'h41C,
    parameter int ISR_OFS    = 'h42C,
    parameter int CH_STRIDE  = 'h40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_en,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    input  logic [CH_N-1:0]          rx_valid,
    input  logic [CH_N*BYTE_W-1:0]   rx_data,
    output logic [CH_N-1:0]          rx_ready,
    output logic [CH_N-1:0]          tx_valid,
    output logic [CH_N*BYTE_W-1:0]   tx_data,
    output logic [CH_N-1:0]          flush_req,
    input  logic                     tick,
    output logic                     irq
);
    localparam logic [BYTE_W-1:0] TX_ALL = tx_isr_all();
    localparam int CLR_CH = 0;   // only this channel's status read drops the line

    core_t q, d;

    logic [CH_N-1:0] hit_sts, hit_cmd, hit_hold;
    logic            hit_isr;
    logic [CH_N-1:0] arrive;
    logic            tx_fire;
    logic            rd, wr;
    logic            irq_set, irq_clr;
    logic [CH_N-1:0] sts_rd;

    con_addr_dec #(
        .ADDR_W(ADDR_W), .CH_N(CH_N),
        .STS_A_OFS(STS_A_OFS), .CMD_A_OFS(CMD_A_OFS),
        .HOLD_A_OFS(HOLD_A_OFS), .ISR_OFS(ISR_OFS), .CH_STRIDE(CH_STRIDE)
    ) u_dec (
        .addr(bus_addr), .hit_sts(hit_sts), .hit_cmd(hit_cmd),
        .hit_hold(hit_hold), .hit_isr(hit_isr)
    );

    con_tick_div #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fire(tx_fire)
    );

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_rx
        con_rx_track u_trk (
            .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid[ch]),
            .pop(rx_ready[ch]), .arrive(arrive[ch])
        );
    end

    assign rd     = bus_en && !bus_we;
    assign wr     = bus_en &&  bus_we;
    assign sts_rd = rd ? hit_sts : '0;

    always_comb begin
        d         = q;
        d.tx_vld  = '0;
        d.flush   = '0;
        bus_rdata = '0;
        rx_ready  = '0;
        irq_set   = 1'b0;
        irq_clr   = 1'b0;

        // shared status/mask address
        if (wr && hit_isr) d.imr = bus_wdata;
        if (rd && hit_isr) bus_rdata = q.isr;

        // per-channel accesses (clears first)
        for (int ch = 0; ch < CH_N; ch++) begin
            if (sts_rd[ch]) begin
                bus_rdata[STS_TX_BIT] = 1'b1;
                bus_rdata[STS_RX_BIT] = rx_valid[ch];
                if (ch == CLR_CH) irq_clr = 1'b1;
            end
            if (wr && hit_cmd[ch] && bus_wdata[CMD_FLUSH_BIT])
                d.flush[ch] = 1'b1;
            if (wr && hit_hold[ch]) begin
                d.tx_vld[ch]                 = 1'b1;
                d.tx_dat[ch*BYTE_W +: BYTE_W] = bus_wdata;
                d.isr[tx_isr_bit(ch)]        = 1'b0;
            end
            if (rd && hit_hold[ch]) begin
                d.isr[rx_isr_bit(ch)] = 1'b0;
                if (rx_valid[ch]) begin
                    bus_rdata    = rx_data[ch*BYTE_W +: BYTE_W];
                    rx_ready[ch] = 1'b1;
                end
            end
        end

        // event sets (win over clears in the same cycle)
        for (int ch = 0; ch < CH_N; ch++) begin
            if (arrive[ch] && q.imr[rx_isr_bit(ch)]) begin
                d.isr[rx_isr_bit(ch)] = 1'b1;
                irq_set               = 1'b1;
            end
        end
        if (tx_fire && |(q.imr & TX_ALL)) begin
            d.isr   = d.isr | TX_ALL;
            irq_set = 1'b1;
        end

        if (irq_set)      d.irq = 1'b1;
        else if (irq_clr) d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_valid  = q.tx_vld;
    assign tx_data   = q.tx_dat;
    assign flush_req = q.flush;
    assign irq       = q.irq;
endmodule

// File: rtl/con_irq_regs_chk.sv
module con_irq_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_en,
    input logic       bus_we,
    input logic [1:0] sts_rd,
    input logic       sts_tx_bit,
    input logic       irq,
    input logic       irq_set,
    input logic [1:0] rx_valid,
    input logic [1:0] rx_ready,
    input logic [1:0] tx_valid,
    input logic [1:0] flush_req
);
    // R2: transmitter-ready bit reads as one on any status read
    p_tx_ready_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|sts_rd) |-> sts_tx_bit);

    // R3: the line only rises after a set event
    p_irq_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_set));

    // R5: channel A status read drops the line
    p_sts_a_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd[0] && !irq_set) |=> !irq);

    // R6: at most one transmit strobe per cycle (one bus access)
    p_one_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_valid));

    // R7: a pop only happens with a byte present
    p_pop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready & ~rx_valid) == 2'b00);

    // R8: flush request follows a bus write
    p_flush_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|flush_req) |-> $past(bus_en && bus_we));
endmodule

bind con_irq_regs con_irq_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .sts_rd(sts_rd), .sts_tx_bit(bus_rdata[2]), .irq(irq), .irq_set(irq_set),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .flush_req(flush_req)
);

// File: tb/con_irq_regs_test.sv
module con_irq_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  rx_valid = '0;
    logic [15:0] rx_data = '0;
    logic [1:0]  rx_ready, tx_valid, flush_req;
    logic [15:0] tx_data;
    logic        tick = 1'b0;
    logic        irq;

    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    con_irq_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .flush_req(flush_req),
        .tick(tick), .irq(irq)
    );

    localparam logic [11:0] A_STA = 12'h40C, A_CMD = 12'h414, A_HLD = 12'h41C;
    localparam logic [11:0] A_ISR = 12'h42C;
    localparam logic [11:0] B_STA = 12'h44C, B_CMD = 12'h454, B_HLD = 12'h45C;

    // {is_read_check, addr, wdata, expected}
    localparam int NV = 10;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, A_ISR,   8'h00, 8'h00},  // R1 status after reset
        {1'b0, A_ISR,   8'h33, 8'h00},  // load mask
        {1'b1, A_ISR,   8'h00, 8'h00},  // R9 read shows status, not mask
        {1'b1, A_STA,   8'h00, 8'h04},  // R2 status A idle
        {1'b1, B_STA,   8'h00, 8'h04},  // R2 status B idle
        {1'b1, 12'h404, 8'h00, 8'h00},  // R10 mode address
        {1'b0, 12'h404, 8'hFF, 8'h00},  // R10 write ignored
        {1'b1, 12'h404, 8'h00, 8'h00},  // R10 still zero
        {1'b1, A_CMD,   8'h00, 8'h00},  // R10 command reads zero
        {1'b1, 12'h7FC, 8'h00, 8'h00}   // R10 unmapped
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic bwr(input logic [11:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic brd(input logic [11:0] a, output logic [7:0] v, output logic [1:0] rdy);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata; rdy = rx_ready;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic rx_put(input int ch, input logic [7:0] b);
        @(negedge clk);
        rx_valid[ch] = 1'b1; rx_data[ch*8 +: 8] = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [1:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", {15'd0, irq}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][28]) begin
                brd(VEC[i][27:16], v, r);
                chk($sformatf("R2/R9/R10 vector %0d", i), {8'd0, v}, {8'd0, VEC[i][7:0]});
            end else begin
                bwr(VEC[i][27:16], VEC[i][15:8]);
            end
        end

        // channel A receive, mask 0x33
        rx_put(0, 8'h5A);
        chk("R3 irq on A arrival", {15'd0, irq}, 16'd1);
        brd(A_ISR, v, r); chk("R3 status A rx", {8'd0, v}, 16'h02);
        brd(A_STA, v, r); chk("R2 status A with byte", {8'd0, v}, 16'h05);
        chk("R5 status A read clears irq", {15'd0, irq}, 16'd0);
        brd(A_HLD, v, r);
        rx_valid[0] = 1'b0;
        chk("R7 holding A data", {8'd0, v}, 16'h5A);
        chk("R7 holding A pop", {14'd0, r}, 16'd1);
        brd(A_ISR, v, r); chk("R7 rx status cleared", {8'd0, v}, 16'h00);
        brd(A_HLD, v, r);
        chk("R7 empty read data", {8'd0, v}, 16'h00);
        chk("R7 empty read no pop", {14'd0, r}, 16'd0);
        chk("R3 no repeat irq", {15'd0, irq}, 16'd0);

        // channel B receive
        rx_put(1, 8'hC3);
        chk("R3 irq on B arrival", {15'd0, irq}, 16'd1);
        brd(A_ISR, v, r); chk("R3 status B rx", {8'd0, v}, 16'h20);
        brd(B_STA, v, r); chk("R2 status B with byte", {8'd0, v}, 16'h05);
        chk("R5 status B read keeps irq", {15'd0, irq}, 16'd1);
        brd(A_STA, v, r); chk("R5 status A read drops irq", {15'd0, irq}, 16'd0);
        brd(B_HLD, v, r);
        rx_valid[1] = 1'b0;
        chk("R7 holding B data", {8'd0, v}, 16'hC3);
        chk("R7 holding B pop", {14'd0, r}, 16'd2);

        // masked arrival
        bwr(A_ISR, 8'h00);
        rx_put(0, 8'h11);
        chk("R3 masked arrival no irq", {15'd0, irq}, 16'd0);
        brd(A_ISR, v, r); chk("R3 masked arrival no status", {8'd0, v}, 16'h00);
        brd(A_HLD, v, r);
        rx_valid[0] = 1'b0;

        // transmit-ready ticks
        bwr(A_ISR, 8'h01);
        do_tick();
        brd(A_ISR, v, r); chk("R4 first tick no event", {8'd0, v}, 16'h00);
        chk("R4 first tick no irq", {15'd0, irq}, 16'd0);
        do_tick();
        brd(A_ISR, v, r); chk("R4 second tick event", {8'd0, v}, 16'h11);
        chk("R4 second tick irq", {15'd0, irq}, 16'd1);
        brd(A_STA, v, r);
        bwr(A_HLD, 8'h41);
        chk("R6 tx strobe A", {14'd0, tx_valid}, 16'd1);
        chk("R6 tx byte A", {8'd0, tx_data[7:0]}, 16'h41);
        brd(A_ISR, v, r); chk("R6 tx A bit cleared", {8'd0, v}, 16'h10);
        bwr(B_HLD, 8'h42);
        chk("R6 tx strobe B", {14'd0, tx_valid}, 16'd2);
        chk("R6 tx byte B", {8'd0, tx_data[15:8]}, 16'h42);
        brd(A_ISR, v, r); chk("R6 tx B bit cleared", {8'd0, v}, 16'h00);
        chk("R6 strobe one cycle", {14'd0, tx_valid}, 16'd0);

        bwr(A_ISR, 8'h22);
        do_tick(); do_tick();
        brd(A_ISR, v, r); chk("R4 tx mask clear no event", {8'd0, v}, 16'h00);
        chk("R4 tx mask clear no irq", {15'd0, irq}, 16'd0);

        // flush
        bwr(A_CMD, 8'h08); chk("R8 flush A", {14'd0, flush_req}, 16'd1);
        bwr(A_CMD, 8'hF7); chk("R8 no flush bit3 clear", {14'd0, flush_req}, 16'd0);
        bwr(B_CMD, 8'h08); chk("R8 flush B", {14'd0, flush_req}, 16'd2);

        // mask write does not touch status
        bwr(A_ISR, 8'hFF);
        brd(A_ISR, v, r); chk("R9 mask write keeps status", {8'd0, v}, 16'h00);

        // reset clears the tick counter
        do_tick();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        brd(A_ISR, v, r); chk("R1 status after mid reset", {8'd0, v}, 16'h00);
        bwr(A_ISR, 8'h01);
        do_tick();
        brd(A_ISR, v, r); chk("R1 counter cleared by reset", {8'd0, v}, 16'h00);
        do_tick();
        brd(A_ISR, v, r); chk("R1 event on second tick after reset", {8'd0, v}, 16'h11);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule